// File: doc/BRIEF.md
# Operand Read Suppression Cache

This block sits beside the register-file read ports of an execution pipeline. It sees one instruction per cycle: up to three source register indices, each with a valid bit and a scalar flag, a SIMD16 mode flag, and a destination index. For every source slot it reports whether the read can be skipped, either because an earlier source of the same instruction already fetches that register or because the slot's small tag cache still holds it from a previous instruction. It also reports how many register-file reads are actually issued. Only tags are held. Register data never passes through the block.

The three slots differ in what they hold. The first-source and third-source slots each keep one tag. The second-source slot keeps two tags and replaces the older one on a miss. A hit across instructions is honoured only on the second and third slots. A duplicate inside one instruction is honoured on any slot. Any write to a cached register removes that register from the cache before the next lookup. An instruction in SIMD16 mode that has a scalar source turns suppression off, and it leaves an empty cache for the instruction after it.

Top module: `opnd_rs_cache`

## Requirements
- R1: After reset `out_vld` is low and every cache entry is empty, so the first instruction after reset gets no cross-instruction hit.
- R2: The results for an instruction accepted with `in_vld` high appear on `out_vld`, `sup_o` and `rd_cnt` on the next rising clock edge. `out_vld` is low in the cycle after a cycle with `in_vld` low.
- R3: Within one instruction, a valid source at slot i is suppressed when a valid source at a lower slot has the same index. This holds for every slot.
- R4: Slot 1 (bit 1 of `sup_o`) is suppressed when its index matches either of its two valid cached tags.
- R5: Slot 2 (bit 2 of `sup_o`) is suppressed when its index matches its one valid cached tag.
- R6: Slot 0 never gets a cross-instruction hit. Because no source comes before it, bit 0 of `sup_o` is always 0.
- R7: When a valid source misses its slot, the slot takes that index. Slot 1 keeps its two most recent distinct misses and evicts the older one. A hit leaves the slot unchanged.
- R8: When `dst_vld` is high, every entry equal to `dst_idx` is invalid for the next instruction's lookup. This includes an entry filled by the same instruction.
- R9: If `simd16` is high and any valid source has its scalar flag set, all `sup_o` bits are 0 for that instruction and the cache is emptied. The next instruction therefore gets no cross-instruction hit.
- R10: An invalid source is never suppressed, issues no read and does not fill its slot.
- R11: `rd_cnt` equals the number of valid sources minus the number of suppressed sources.
- R12: Cycles with `in_vld` low leave the cache contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld | input | 1 | An instruction is presented this cycle |
| src_idx | input | 3 x IW | Source register indices; element i belongs to slot i |
| src_vld | input | 3 | Source present, one bit per slot |
| src_scalar | input | 3 | Source is a scalar operand, one bit per slot |
| simd16 | input | 1 | Instruction runs in SIMD16 mode |
| dst_vld | input | 1 | Instruction writes a destination register |
| dst_idx | input | IW | Destination register index |
| out_vld | output | 1 | Results below belong to the previous cycle's instruction |
| sup_o | output | 3 | Per-slot suppress bits |
| rd_cnt | output | 2 | Number of register-file reads issued |

## Verification
Every result is registered once, so the outputs for an instruction driven before edge k are due just after edge k. The bench drives on the falling edge and compares at the following falling edge, half a period after the capturing edge. Back-to-back instructions therefore check that a destination invalidation and a SIMD16-scalar flush take effect by the very next lookup. The behavioural reference model advances its cache in the same step in which it produces the expected values. Each comparison then concerns exactly the instruction driven one cycle earlier, and an idle cycle is expected to show `out_vld` low.

// File: rtl/osc_pkg.sv
// Shared constants and per-slot configuration for the operand read
// suppression cache. Assumes exactly three source slots.
package osc_pkg;
    localparam int NSRC = 3;
    localparam int CNT_W = $clog2(NSRC + 1);

    // Number of tags a slot keeps.
    function automatic int slot_depth(input int slot);
        return (slot == 1) ? 2 : 1;
    endfunction

    // Whether a slot may be served from a previous instruction's read.
    function automatic bit slot_xhit(input int slot);
        return (slot == 1) || (slot == 2);
    endfunction
endpackage

// File: rtl/osc_slot.sv
// Tag cache for one source slot. It holds DEPTH tags; the newest is at
// entry 0. On a miss by a valid read the tags shift down and the new
// index enters at entry 0. A destination write clears the matching
// entries after the fill. kill empties the slot. Updates happen only
// when step is high. Assumes one lookup per step.
module osc_slot #(
    parameter int IW    = 7,
    parameter int DEPTH = 1,
    parameter bit XHIT  = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          kill,
    input  logic          rd_vld,
    input  logic [IW-1:0] rd_idx,
    input  logic          inv_vld,
    input  logic [IW-1:0] inv_idx,
    output logic          hit_o
);
    logic [DEPTH-1:0] ent_v;
    logic [IW-1:0]    ent_t [DEPTH];
    logic [DEPTH-1:0] match;
    logic [DEPTH-1:0] nxt_v;
    logic [IW-1:0]    nxt_t [DEPTH];
    logic             present;
    logic             fill;

    // Compare the request against every held tag.
    always_comb begin
        for (int d = 0; d < DEPTH; d++) begin
            match[d] = ent_v[d] && (ent_t[d] == rd_idx);
        end
    end

    assign present = |match;
    assign fill    = rd_vld && !present;
    assign hit_o   = XHIT && rd_vld && present;

    // Next-state per entry: shift on fill, then clear on destination write.
    for (genvar d = 0; d < DEPTH; d++) begin : g_ent
        logic [IW-1:0] sh_t;
        logic          sh_v;
        if (d == 0) begin : g_head
            assign sh_t = rd_idx;
            assign sh_v = 1'b1;
        end else begin : g_tail
            assign sh_t = ent_t[d-1];
            assign sh_v = ent_v[d-1];
        end
        assign nxt_t[d] = fill ? sh_t : ent_t[d];
        assign nxt_v[d] = (fill ? sh_v : ent_v[d])
                          && !(inv_vld && (nxt_t[d] == inv_idx));
    end

    // Valid bits: reset, flush or advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_v <= '0;
        end else if (step) begin
            ent_v <= kill ? '0 : nxt_v;
        end
    end

    // Tags carry no reset; they only matter while their valid bit is set.
    always_ff @(posedge clk) begin
        if (step) begin
            for (int d = 0; d < DEPTH; d++) begin
                ent_t[d] <= nxt_t[d];
            end
        end
    end
endmodule

// File: rtl/osc_intra.sv
// Duplicate detection inside one instruction. A valid source is marked
// when any valid source at a lower slot carries the same index.
// Purely combinational.
module osc_intra #(
    parameter int IW = 7,
    parameter int N  = 3
) (
    input  logic [N-1:0][IW-1:0] idx,
    input  logic [N-1:0]         vld,
    output logic [N-1:0]         dup_o
);
    // Scan lower slots for an equal valid index.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            dup_o[i] = 1'b0;
            for (int j = 0; j < i; j++) begin
                if (vld[i] && vld[j] && (idx[j] == idx[i])) begin
                    dup_o[i] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/opnd_rs_cache.sv
// Operand read suppression cache. Takes one instruction per cycle and
// returns the per-slot suppress bits and the read count one cycle later.
// SIMD16 with a scalar source disables suppression and flushes all
// slots. Assumes the destination write of an instruction lands before
// the next instruction's lookup.
module opnd_rs_cache
    import osc_pkg::*;
#(
    parameter int IW = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_vld,
    input  logic [NSRC-1:0][IW-1:0] src_idx,
    input  logic [NSRC-1:0]         src_vld,
    input  logic [NSRC-1:0]         src_scalar,
    input  logic                    simd16,
    input  logic                    dst_vld,
    input  logic [IW-1:0]           dst_idx,
    output logic                    out_vld,
    output logic [NSRC-1:0]         sup_o,
    output logic [CNT_W-1:0]        rd_cnt
);
    logic            no_sup;
    logic [NSRC-1:0] dup;
    logic [NSRC-1:0] hit;
    logic [NSRC-1:0] sup_c;
    logic [CNT_W-1:0] cnt_c;

    // SIMD16 with any valid scalar source turns suppression off.
    assign no_sup = simd16 && |(src_vld & src_scalar);

    osc_intra #(.IW(IW), .N(NSRC)) u_intra (
        .idx   (src_idx),
        .vld   (src_vld),
        .dup_o (dup)
    );

    for (genvar s = 0; s < NSRC; s++) begin : g_slot
        osc_slot #(
            .IW    (IW),
            .DEPTH (slot_depth(s)),
            .XHIT  (slot_xhit(s))
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .step    (in_vld),
            .kill    (no_sup),
            .rd_vld  (src_vld[s]),
            .rd_idx  (src_idx[s]),
            .inv_vld (dst_vld),
            .inv_idx (dst_idx),
            .hit_o   (hit[s])
        );
    end

    assign sup_c = no_sup ? '0 : (src_vld & (dup | hit));

    // Count the sources that really read the register file.
    always_comb begin
        cnt_c = '0;
        for (int s = 0; s < NSRC; s++) begin
            cnt_c = cnt_c + CNT_W'(src_vld[s] && !sup_c[s]);
        end
    end

    // Register the per-instruction results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            sup_o   <= '0;
            rd_cnt  <= '0;
        end else begin
            out_vld <= in_vld;
            sup_o   <= in_vld ? sup_c : '0;
            rd_cnt  <= in_vld ? cnt_c : '0;
        end
    end
endmodule

// File: rtl/osc_chk.sv
// Property checker for opnd_rs_cache, attached through bind.
module osc_chk
    import osc_pkg::*;
#(
    parameter int IW = 7
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_vld,
    input logic [NSRC-1:0][IW-1:0] src_idx,
    input logic [NSRC-1:0]         src_vld,
    input logic [NSRC-1:0]         src_scalar,
    input logic                    simd16,
    input logic                    out_vld,
    input logic [NSRC-1:0]         sup_o,
    input logic [CNT_W-1:0]        rd_cnt
);
    // R2
    idle_no_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);

    // R2
    busy_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);

    // R6
    slot0_never_sup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> !sup_o[0]);

    // R9
    scalar_simd16_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && simd16 && |(src_vld & src_scalar)) |=> (sup_o == '0));

    // R10
    invalid_src_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> ((sup_o & ~$past(src_vld)) == '0));

    // R11
    read_count_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> (int'(rd_cnt) + $countones(sup_o) == $countones($past(src_vld))));

    // R3
    dup_slot1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !(simd16 && |(src_vld & src_scalar)) && src_vld[0] && src_vld[1]
         && (src_idx[0] == src_idx[1])) |=> sup_o[1]);
endmodule

bind opnd_rs_cache osc_chk #(.IW(IW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_vld     (in_vld),
    .src_idx    (src_idx),
    .src_vld    (src_vld),
    .src_scalar (src_scalar),
    .simd16     (simd16),
    .out_vld    (out_vld),
    .sup_o      (sup_o),
    .rd_cnt     (rd_cnt)
);

// File: tb/sim_opnd_rs_cache.sv
`timescale 1ns/1ps
module sim_opnd_rs_cache;
    localparam int IW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_vld = 1'b0;
    logic [2:0][IW-1:0] src_idx = '0;
    logic [2:0]    src_vld = '0;
    logic [2:0]    src_scalar = '0;
    logic          simd16 = 1'b0;
    logic          dst_vld = 1'b0;
    logic [IW-1:0] dst_idx = '0;
    logic          out_vld;
    logic [2:0]    sup_o;
    logic [1:0]    rd_cnt;

    int n_chk = 0;
    int n_bad = 0;

    // Reference cache state: slot 0 and slot 2 one tag, slot 1 two tags (newest first).
    int m0t, m2t;
    bit m0v, m2v;
    int m1t[2];
    bit m1v[2];

    always #4 clk = ~clk;

    opnd_rs_cache #(.IW(IW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .src_idx(src_idx),
        .src_vld(src_vld), .src_scalar(src_scalar), .simd16(simd16),
        .dst_vld(dst_vld), .dst_idx(dst_idx), .out_vld(out_vld),
        .sup_o(sup_o), .rd_cnt(rd_cnt)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        m0v = 0; m2v = 0; m1v[0] = 0; m1v[1] = 0;
    endtask

    // Drive one instruction, advance the model, compare after the capturing edge.
    task automatic issue(input int i0, input int i1, input int i2, input bit [2:0] v,
                         input bit [2:0] sc, input bit s16, input bit dv, input int d,
                         input string tag);
        int idx[3];
        bit [2:0] esup;
        int ecnt;
        bit dis;
        idx[0] = i0; idx[1] = i1; idx[2] = i2;
        dis = s16 && ((v & sc) != 0);
        esup = '0;
        for (int i = 0; i < 3; i++) begin
            bit h;
            h = 0;
            for (int j = 0; j < i; j++) if (v[j] && idx[j] == idx[i]) h = 1;
            if (i == 1 && ((m1v[0] && m1t[0] == idx[1]) || (m1v[1] && m1t[1] == idx[1]))) h = 1;
            if (i == 2 && m2v && m2t == idx[2]) h = 1;
            esup[i] = !dis && v[i] && h;
        end
        ecnt = 0;
        for (int i = 0; i < 3; i++) if (v[i] && !esup[i]) ecnt++;
        if (dis) model_clear();
        else begin
            if (v[0] && !(m0v && m0t == i0)) begin m0t = i0; m0v = 1; end
            if (v[1] && !((m1v[0] && m1t[0] == i1) || (m1v[1] && m1t[1] == i1))) begin
                m1t[1] = m1t[0]; m1v[1] = m1v[0]; m1t[0] = i1; m1v[0] = 1;
            end
            if (v[2] && !(m2v && m2t == i2)) begin m2t = i2; m2v = 1; end
            if (dv) begin
                if (m0t == d) m0v = 0;
                if (m2t == d) m2v = 0;
                for (int k = 0; k < 2; k++) if (m1t[k] == d) m1v[k] = 0;
            end
        end
        in_vld = 1; src_idx[0] = IW'(i0); src_idx[1] = IW'(i1); src_idx[2] = IW'(i2);
        src_vld = v; src_scalar = sc; simd16 = s16; dst_vld = dv; dst_idx = IW'(d);
        @(negedge clk);
        check(out_vld === 1'b1, {tag, " R2 out_vld"}, int'(out_vld), 1);
        check(sup_o === esup, {tag, " sup"}, int'(sup_o), int'(esup));
        check(rd_cnt === 2'(ecnt), {tag, " R11 rd_cnt"}, int'(rd_cnt), ecnt);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            in_vld = 0;
            src_idx = '1; src_vld = '1; dst_vld = 1; dst_idx = '0;
            @(negedge clk);
            check(out_vld === 1'b0, "R12 R2 idle out_vld", int'(out_vld), 0);
        end
    endtask

    initial begin
        #200000;
        n_bad++; n_chk++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        model_clear();
        m0t = 0; m2t = 0; m1t[0] = 0; m1t[1] = 0;
        repeat (3) @(negedge clk);
        check(out_vld === 1'b0, "R1 reset out_vld", int'(out_vld), 0);
        rst_n = 1;
        @(negedge clk);
        check(out_vld === 1'b0, "R1 idle after reset", int'(out_vld), 0);
        // R1: cold cache, expect sup 000
        issue(3, 5, 7, 3'b111, 0, 0, 0, 0, "R1 cold");
        // R4 R5 R6: repeat, slots 1 and 2 hit, slot 0 does not
        issue(3, 5, 7, 3'b111, 0, 0, 0, 0, "R4 R5 R6 repeat");
        // R7: slot 1 miss fills -> {9,5}
        issue(0, 9, 7, 3'b110, 0, 0, 0, 0, "R7 fill");
        // R4: older tag 5 still hits
        issue(0, 5, 0, 3'b010, 0, 0, 0, 0, "R4 older tag");
        // R7: 11 evicts 5, then 5 misses
        issue(0, 11, 0, 3'b010, 0, 0, 0, 0, "R7 evict");
        issue(0, 5, 0, 3'b010, 0, 0, 0, 0, "R7 evicted miss");
        // R3: in-instruction duplicates
        issue(20, 20, 20, 3'b111, 0, 0, 0, 0, "R3 dup all");
        issue(21, 22, 21, 3'b111, 0, 0, 0, 0, "R3 dup slot2");
        // R8: destination write kills just-filled tag, back-to-back lookup misses
        issue(0, 30, 31, 3'b110, 0, 0, 1, 31, "R8 write");
        issue(0, 30, 31, 3'b110, 0, 0, 0, 0, "R8 next lookup");
        // R9: SIMD16 with scalar source: no suppression, then flushed cache
        issue(40, 40, 40, 3'b111, 3'b001, 1, 0, 0, "R9 off");
        issue(0, 40, 40, 3'b110, 0, 0, 0, 0, "R9 flushed");
        // R9: SIMD16 without scalar keeps suppression
        issue(0, 40, 40, 3'b110, 0, 1, 0, 0, "R9 simd16 no scalar");
        // R10: invalid source neither suppressed nor filled
        issue(50, 50, 51, 3'b001, 0, 0, 0, 0, "R10 invalid");
        issue(0, 51, 51, 3'b110, 0, 0, 0, 0, "R10 no fill");
        // R12: idle cycles keep the cache
        idle(3);
        issue(0, 51, 51, 3'b110, 0, 0, 0, 0, "R12 after idle");
        // Random stream over a small index range
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(9) == 0) idle(1);
            else issue($urandom_range(7), $urandom_range(7), $urandom_range(7),
                       3'($urandom), ($urandom_range(3) == 0) ? 3'($urandom) : 3'b000,
                       1'($urandom), 1'($urandom), $urandom_range(7), "R3 R4 R5 R8 R11 random");
        end
        in_vld = 0;
        @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule